// File: doc/BRIEF.md
# Dual-Domain Priority Bus Arbiter

This block grants two buses at once. The on-chip bus domain serves three requesters: a DMA controller, a data transfer controller and the CPU. The off-chip bus domain serves four requesters: a memory refresh engine, an external DMA engine, an external bus-release requester, and the external accesses made by the on-chip masters. Each requester raises a request line and holds the bus for as long as its grant line stays high. To end its tenure, a requester drops its request.

Each domain normally uses a fixed priority order. Each domain also has an enable input for an alternation mode. In that mode the lowest-priority requester takes turns with the higher-priority ones, so that steady higher-priority traffic cannot starve it. The order among the higher-priority requesters does not change in alternation mode. The two domains share no state and decide in the same clock.

Top module: `dual_bus_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, every grant is low. Both alternation modes are off, and both turn flags are cleared.
- R2: On-chip domain request and grant bits are: bit 0 DMA controller, bit 1 data transfer controller, bit 2 CPU. In fixed mode, an idle domain grants the lowest-numbered requesting bit. The grant appears on the clock edge after the requests are sampled.
- R3: Off-chip domain bits are: bit 0 refresh, bit 1 external DMA, bit 2 bus-release requester, bit 3 on-chip masters' external access. In fixed mode, the lowest-numbered requesting bit wins.
- R4: While the granted requester keeps its request high, its grant stays high and does not change, even when a higher-priority request arrives.
- R5: When the granted requester's request is seen low at a clock edge, all grants of that domain go low at that edge. A new grant can appear no earlier than the next edge.
- R6: In each domain, at most one grant is high at any time.
- R7: In on-chip alternation mode, when the CPU competes with DMA or data transfer requests, the CPU wins if the last completed tenure was not the CPU's. Otherwise the higher class wins. After reset, the CPU wins the first such contest.
- R8: In alternation mode, whenever a requester other than the lowest one is granted, it is the lowest-numbered requester among bits below the top bit. The fixed order among those bits is kept.
- R9: Off-chip alternation mode behaves as R7, with bit 3 as the lowest class against bits 0 to 2.
- R10: The two domains decide independently. A grant in one domain neither blocks nor delays a grant in the other, and both can be high in the same cycle.
- R11: An alternation enable input is registered. A change takes effect on arbitration decisions one clock after it is sampled.
- R12: A grant is only issued from an idle domain, and only to a requester whose request was high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_alt_en | input | 1 | On-chip domain alternation enable |
| ext_alt_en | input | 1 | Off-chip domain alternation enable |
| int_req | input | INT_N | On-chip requests (bit 0 highest priority) |
| ext_req | input | EXT_N | Off-chip requests (bit 0 highest priority) |
| int_gnt | output | INT_N | On-chip grants, registered |
| ext_gnt | output | EXT_N | Off-chip grants, registered |

## Verification
The assertions assume that a requester whose grant ends keeps its request low, or raises it again, only as an ordinary new request. They also assume that request inputs change only between clock edges, so each decision sees one stable request vector. The stimulus changes requests and enables only on the falling clock edge. It ends every tenure by clearing the granted bit. It sets alternation enables one step before the contest they are meant to affect, and in one step changes an enable together with a contest to show the one-clock lag.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned INT_MASTERS = 3;
  localparam int unsigned EXT_MASTERS = 4;

  typedef enum logic {TURN_HIGH = 1'b0, TURN_LOW = 1'b1} turn_e;
endpackage

// File: rtl/arb_select.sv
module arb_select #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  input  logic         alt,
  input  logic         low_had_turn,
  output logic [N-1:0] pick
);
  localparam int unsigned LOW = N - 1;
  localparam logic [N-1:0] HIGH_MASK = {1'b0, {(N-1){1'b1}}};

  logic [N-1:0] high_req;
  logic [N-1:0] high_pick;
  logic [N-1:0] full_pick;
  logic [N-1:0] low_only;

  assign high_req  = req & HIGH_MASK;
  assign high_pick = high_req & (~high_req + 1'b1);
  assign full_pick = req & (~req + 1'b1);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_low
      assign low_only[g] = (g == LOW) ? 1'b1 : 1'b0;
    end
  endgenerate

  always_comb begin
    if (alt && req[LOW] && (high_req != '0)) begin
      pick = low_had_turn ? high_pick : low_only;
    end else begin
      pick = full_pick;
    end
  end
endmodule

// File: rtl/arb_domain.sv
module arb_domain #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         alt_en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  import arb_pkg::*;
  localparam int unsigned LOW = N - 1;

  logic [N-1:0] gnt_q;
  logic [N-1:0] pick;
  logic         alt_q;
  turn_e        turn_q;
  logic         owner_active;

  assign owner_active = (req & gnt_q) != '0;

  arb_select #(.N(N)) u_sel (
    .req          (req),
    .alt          (alt_q),
    .low_had_turn (turn_q == TURN_LOW),
    .pick         (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      alt_q  <= 1'b0;
      turn_q <= TURN_HIGH;
    end else begin
      alt_q <= alt_en;
      if (gnt_q != '0) begin
        if (!owner_active) begin
          gnt_q  <= '0;
          turn_q <= gnt_q[LOW] ? TURN_LOW : TURN_HIGH;
        end
      end else begin
        gnt_q <= pick;
      end
    end
  end

  assign gnt = gnt_q;

  // R6
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  // R4: no preemption during a tenure
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != '0 && owner_active) |=> gnt_q == $past(gnt_q));

  // R5: a dropped request frees the domain at once
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != '0 && !owner_active) |=> gnt_q == '0);

  // R12: new grants only go to a requester
  p_grant_req_r12: assert property (@(posedge clk) disable iff (rst)
    (gnt_q == '0) |=> (gnt_q == '0) || ((gnt_q & $past(req)) != '0));

  // R2 / R3: fixed mode, nothing of higher priority was waiting
  p_fixed_order_r2: assert property (@(posedge clk) disable iff (rst)
    (!alt_q && gnt_q == '0 && req != '0) |=>
      (gnt_q != '0) && (((gnt_q - 1'b1) & $past(req)) == '0));

  // R8: order among the higher class kept in alternation mode
  p_high_order_r8: assert property (@(posedge clk) disable iff (rst)
    (alt_q && gnt_q == '0 && req != '0) |=>
      (gnt_q != '0) && (gnt_q[LOW] || (((gnt_q - 1'b1) & $past(req)) == '0)));

  // R7 / R9: the lowest class gets its turn
  p_low_turn_r7: assert property (@(posedge clk) disable iff (rst)
    (alt_q && gnt_q == '0 && req[LOW] && (req[LOW-1:0] != '0) && turn_q == TURN_HIGH)
      |=> gnt_q[LOW]);

  // R7 / R9: the higher class gets the next turn
  p_high_turn_r9: assert property (@(posedge clk) disable iff (rst)
    (alt_q && gnt_q == '0 && req[LOW] && (req[LOW-1:0] != '0) && turn_q == TURN_LOW)
      |=> !gnt_q[LOW] && gnt_q != '0);
endmodule

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter #(
  parameter int unsigned INT_N = arb_pkg::INT_MASTERS,
  parameter int unsigned EXT_N = arb_pkg::EXT_MASTERS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_alt_en,
  input  logic             ext_alt_en,
  input  logic [INT_N-1:0] int_req,
  input  logic [EXT_N-1:0] ext_req,
  output logic [INT_N-1:0] int_gnt,
  output logic [EXT_N-1:0] ext_gnt
);
  arb_domain #(.N(INT_N)) u_int (
    .clk    (clk),
    .rst    (rst),
    .alt_en (int_alt_en),
    .req    (int_req),
    .gnt    (int_gnt)
  );

  arb_domain #(.N(EXT_N)) u_ext (
    .clk    (clk),
    .rst    (rst),
    .alt_en (ext_alt_en),
    .req    (ext_req),
    .gnt    (ext_gnt)
  );

  // R1: quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (int_gnt == '0 && ext_gnt == '0));
endmodule

// File: tb/dual_bus_arbiter_test.sv
module dual_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       int_alt_en = 1'b0;
  logic       ext_alt_en = 1'b0;
  logic [2:0] int_req = '0;
  logic [3:0] ext_req = '0;
  logic [2:0] int_gnt;
  logic [3:0] ext_gnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] ei;
    logic [3:0] ee;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  dual_bus_arbiter uut (
    .clk(clk), .rst(rst), .int_alt_en(int_alt_en), .ext_alt_en(ext_alt_en),
    .int_req(int_req), .ext_req(ext_req), .int_gnt(int_gnt), .ext_gnt(ext_gnt)
  );

  task automatic step(input logic ia, input logic ea, input logic [2:0] ir,
                      input logic [3:0] er, input logic [2:0] xi,
                      input logic [3:0] xe, input string tag);
    exp_t e;
    @(negedge clk);
    int_alt_en = ia;
    ext_alt_en = ea;
    int_req    = ir;
    ext_req    = er;
    e.ei = xi; e.ee = xe; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (int_gnt !== e.ei || ext_gnt !== e.ee) begin
          fails++;
          $display("FAIL %s: int_gnt=%b ext_gnt=%b expected int=%b ext=%b",
                   e.tag, int_gnt, ext_gnt, e.ei, e.ee);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (int_gnt !== 3'b000 || ext_gnt !== 4'b0000) begin
      fails++;
      $display("FAIL R1 in reset: int=%b ext=%b expected 000 0000", int_gnt, ext_gnt);
    end
    @(negedge clk);
    rst = 1'b0;
    // fixed mode
    step(0,0,3'b000,4'b0000,3'b000,4'b0000,"R1 idle after reset");
    step(0,0,3'b111,4'b1111,3'b001,4'b0001,"R2 R3 R10 top priority");
    step(0,0,3'b111,4'b1111,3'b001,4'b0001,"R4 hold");
    step(0,0,3'b110,4'b1110,3'b000,4'b0000,"R5 release");
    step(0,0,3'b110,4'b1110,3'b010,4'b0010,"R2 R3 second");
    step(0,0,3'b100,4'b1100,3'b000,4'b0000,"R5 release 2");
    step(0,0,3'b100,4'b1100,3'b100,4'b0100,"R2 R3 third");
    step(0,0,3'b000,4'b1000,3'b000,4'b0000,"R5 release 3");
    step(0,0,3'b000,4'b1000,3'b000,4'b1000,"R3 lowest alone");
    step(0,0,3'b011,4'b1000,3'b001,4'b1000,"R10 independent");
    step(0,0,3'b010,4'b1001,3'b000,4'b1000,"R4 no preemption");
    step(0,0,3'b010,4'b0001,3'b010,4'b0000,"R12 R10 new grant");
    step(0,0,3'b000,4'b0001,3'b000,4'b0001,"R5 R3 refresh");
    step(0,0,3'b000,4'b0000,3'b000,4'b0000,"R5 idle");
    // alternation mode
    step(1,1,3'b000,4'b0000,3'b000,4'b0000,"R11 enable");
    step(1,1,3'b101,4'b1001,3'b100,4'b1000,"R7 R9 low first");
    step(1,1,3'b001,4'b0001,3'b000,4'b0000,"R5 alt release");
    step(1,1,3'b101,4'b1001,3'b001,4'b0001,"R7 R9 high next");
    step(1,1,3'b100,4'b1000,3'b000,4'b0000,"R5 alt release 2");
    step(1,1,3'b111,4'b1111,3'b100,4'b1000,"R7 R9 low again");
    step(1,1,3'b011,4'b0111,3'b000,4'b0000,"R5 alt release 3");
    step(1,1,3'b011,4'b0111,3'b001,4'b0001,"R8 top high");
    step(1,1,3'b010,4'b0110,3'b000,4'b0000,"R5 alt release 4");
    step(1,1,3'b011,4'b0110,3'b001,4'b0010,"R8 order kept");
    step(1,1,3'b000,4'b0000,3'b000,4'b0000,"R5 alt idle");
    // enable lag
    step(0,0,3'b101,4'b1001,3'b100,4'b1000,"R11 still alt");
    step(0,0,3'b000,4'b0000,3'b000,4'b0000,"R11 release");
    step(0,0,3'b101,4'b1001,3'b001,4'b0001,"R11 fixed");
    step(0,0,3'b100,4'b1000,3'b000,4'b0000,"R11 release 2");
    step(0,0,3'b101,4'b1001,3'b001,4'b0001,"R11 R2 fixed again");
    step(0,0,3'b000,4'b0000,3'b000,4'b0000,"R5 final");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule